// File: doc/BRIEF.md
# Tiled Five-Point Diffusion Stencil Engine

This block advances a two-dimensional explicit diffusion update by one time step for a square tile of three by three output points. Each transaction delivers the 21 grid samples that the nine updates need (the nine interior points plus the twelve edge-adjacent halo points, corners excluded), together with three weights: one for the pair of neighbours along i, one for the pair along j, and one for the centre. The block returns the nine new values in a single output beat. A scheduler outside the block walks the grid in steps of three along both axes and feeds one tile per transaction.

All samples, weights and results are signed Q8.8 fixed-point numbers. The arithmetic is a purely feed-forward pipeline of three register stages, with no feedback path: pair sums, then three weighted products that are each rounded and clamped to 16 bits, then a clamped three-way sum. Both sides use a valid/ready handshake; the whole pipeline advances together and freezes only when a finished tile sits at the output while the consumer is not ready.

Because the nine updates share one fetched neighbourhood, a tile needs 21 samples in and 9 out instead of 45 in and 9 out.

Top module: `stencil_tile`

## Requirements
- R1: While and after reset, `out_valid` is 0 and `in_ready` is 1 until a tile is accepted.
- R2: Each output equals rs(Ci·(w+e)) + rs(Cj·(s+n)) + rs(Cc·c), clamped to the signed 16-bit range, where w/e are the i-1/i+1 neighbours, s/n the j-1/j+1 neighbours, c the centre, and rs is the product rounding of R5 and R6.
- R3: Input sample k sits at `in_taps[16k+15:16k]`. Samples are ordered by row y = j-1, j, j+1, j+2, j+3 and within a row by increasing i; rows j-1 and j+3 carry only i..i+2 (indices 0-2 and 18-20), rows j..j+2 carry i-1..i+3 (five each, indices 3-7, 8-12, 13-17).
- R4: Output point (i+di, j+dj), di and dj in 0..2, sits at `out_vals[16m+15:16m]` with m = 3·dj + di.
- R5: A Q8.8 weight times a Q8.8 value (or pair sum) is rounded by adding 128 to the raw product and shifting right arithmetically by 8 (ties go toward plus infinity).
- R6: Each rounded product, and the final three-term sum, is clamped to -32768..32767.
- R7: With `out_ready` held at 1, a tile accepted at clock edge t appears on `out_valid` after edge t+2 (three register stages), and a new tile is accepted on every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_vals` stays unchanged, `out_valid` stays 1 and `in_ready` is 0.
- R9: Tiles leave in the order they were accepted, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A tile is offered |
| in_ready | output | 1 | The block takes the offered tile at this edge |
| in_taps | input | 336 | 21 Q8.8 samples, ordered as in R3 |
| coef_i | input | 16 | Q8.8 weight for the i-direction pair |
| coef_j | input | 16 | Q8.8 weight for the j-direction pair |
| coef_c | input | 16 | Q8.8 weight for the centre |
| out_valid | output | 1 | Nine results are present |
| out_ready | input | 1 | Consumer takes the results at this edge |
| out_vals | output | 144 | Nine Q8.8 results, ordered as in R4 |

## Verification
The bench pushes tiles with extreme samples and weights so that a single product and the final sum both overflow; a design that wraps instead of clamping returns a value of the wrong sign. Half-LSB products with positive and negative sign expose rounding that truncates or rounds symmetrically, which shifts one result by one LSB. Single-hot tiles isolate each input position, so a swapped halo index or output slot shows up as a value in the wrong lane. Random output backpressure against back-to-back input shows whether a stalled tile is overwritten, duplicated or dropped, and a lone tile with a free output measures the three-stage latency.

// File: rtl/stencil_pkg.sv
package stencil_pkg;

    // Tile edge length: the tile covers TILE x TILE output points.
    localparam int TILE = 3;
    localparam int PTS  = TILE * TILE;
    // Interior rows carry TILE+2 samples, the outer halo rows TILE samples.
    localparam int TAPS = 2 * TILE + TILE * (TILE + 2);

    // Position of sample (x, y) relative to the tile origin in the input bus.
    function automatic int tap_index(input int x, input int y);
        if (y < 0)
            return x;
        else if (y >= TILE)
            return TILE + TILE * (TILE + 2) + x;
        else
            return TILE + y * (TILE + 2) + x + 1;
    endfunction

endpackage

// File: rtl/stencil_ctrl.sv
module stencil_ctrl #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic advance,
    output logic out_valid
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] vld_q;

    // Whole pipeline moves unless a finished tile is held at the output.
    assign advance   = !vld_q[LAST] || out_ready;
    assign out_valid = vld_q[LAST];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (advance) begin
            if (STAGES > 1)
                vld_q <= {vld_q[STAGES-2:0], in_valid};
            else
                vld_q <= in_valid;
        end
    end

endmodule

// File: rtl/stencil_point.sv
module stencil_point #(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] nb_w,
    input  logic signed [DW-1:0] nb_e,
    input  logic signed [DW-1:0] nb_s,
    input  logic signed [DW-1:0] nb_n,
    input  logic signed [DW-1:0] ctr,
    input  logic signed [DW-1:0] w_i,
    input  logic signed [DW-1:0] w_j,
    input  logic signed [DW-1:0] w_c,
    output logic signed [DW-1:0] result
);

    localparam int SW = DW + 1;
    localparam int PW = DW + SW;
    localparam int RW = DW + 2;

    localparam logic signed [PW-1:0] HALF = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [PW-1:0] PMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] PMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [RW-1:0] SMAX = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [RW-1:0] SMIN = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    function automatic logic signed [DW-1:0] round_clamp(input logic signed [PW-1:0] p);
        logic signed [PW-1:0] r;
        r = (p + HALF) >>> FRAC;
        if (r > PMAX)
            return PMAX[DW-1:0];
        else if (r < PMIN)
            return PMIN[DW-1:0];
        else
            return r[DW-1:0];
    endfunction

    // Stage 1: pair sums.
    logic signed [SW-1:0] sum_i_q, sum_j_q;
    logic signed [DW-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_i_q <= '0;
            sum_j_q <= '0;
            ctr_q   <= '0;
        end else if (en) begin
            sum_i_q <= SW'(nb_w) + SW'(nb_e);
            sum_j_q <= SW'(nb_s) + SW'(nb_n);
            ctr_q   <= ctr;
        end
    end

    // Stage 2: weighted, rounded, clamped products.
    logic signed [PW-1:0] raw_i, raw_j, raw_c;
    logic signed [DW-1:0] prd_i_q, prd_j_q, prd_c_q;

    always_comb begin
        raw_i = PW'(sum_i_q) * PW'(w_i);
        raw_j = PW'(sum_j_q) * PW'(w_j);
        raw_c = PW'(ctr_q)   * PW'(w_c);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_i_q <= '0;
            prd_j_q <= '0;
            prd_c_q <= '0;
        end else if (en) begin
            prd_i_q <= round_clamp(raw_i);
            prd_j_q <= round_clamp(raw_j);
            prd_c_q <= round_clamp(raw_c);
        end
    end

    // Stage 3: clamped three-way sum.
    logic signed [RW-1:0] total;

    always_comb begin
        total = RW'(prd_i_q) + RW'(prd_j_q) + RW'(prd_c_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (en) begin
            if (total > SMAX)
                result <= SMAX[DW-1:0];
            else if (total < SMIN)
                result <= SMIN[DW-1:0];
            else
                result <= total[DW-1:0];
        end
    end

endmodule

// File: rtl/stencil_tile.sv
module stencil_tile
    import stencil_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAPS*DW-1:0] in_taps,
    input  logic [DW-1:0]     coef_i,
    input  logic [DW-1:0]     coef_j,
    input  logic [DW-1:0]     coef_c,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PTS*DW-1:0] out_vals
);

    localparam int STAGES = 3;

    logic advance;

    stencil_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .advance   (advance),
        .out_valid (out_valid)
    );

    assign in_ready = advance;

    // Weights aligned with the pair-sum stage.
    logic signed [DW-1:0] wi_q, wj_q, wc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wi_q <= '0;
            wj_q <= '0;
            wc_q <= '0;
        end else if (advance) begin
            wi_q <= coef_i;
            wj_q <= coef_j;
            wc_q <= coef_c;
        end
    end

    for (genvar dj = 0; dj < TILE; dj++) begin : g_row
        for (genvar di = 0; di < TILE; di++) begin : g_col
            localparam int M  = dj * TILE + di;
            localparam int XW = tap_index(di - 1, dj);
            localparam int XE = tap_index(di + 1, dj);
            localparam int XS = tap_index(di, dj - 1);
            localparam int XN = tap_index(di, dj + 1);
            localparam int XC = tap_index(di, dj);

            logic signed [DW-1:0] pt_res;

            stencil_point #(.DW(DW), .FRAC(FRAC)) u_pt (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (advance),
                .nb_w   (in_taps[XW*DW +: DW]),
                .nb_e   (in_taps[XE*DW +: DW]),
                .nb_s   (in_taps[XS*DW +: DW]),
                .nb_n   (in_taps[XN*DW +: DW]),
                .ctr    (in_taps[XC*DW +: DW]),
                .w_i    (wi_q),
                .w_j    (wj_q),
                .w_c    (wc_q),
                .result (pt_res)
            );

            assign out_vals[M*DW +: DW] = pt_res;
        end
    end

endmodule

// File: rtl/stencil_tile_chk.sv
module stencil_tile_chk #(
    parameter int VW     = 144,
    parameter int STAGES = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [VW-1:0] out_vals
);

    logic [3:0] inflight;

    always_ff @(posedge clk) begin
        if (!rst_n)
            inflight <= '0;
        else
            inflight <= inflight + 4'((in_valid && in_ready) ? 1 : 0)
                                 - 4'((out_valid && out_ready) ? 1 : 0);
    end

    // R8: held result stays valid and unchanged
    a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vals));

    // R8: no intake while the output is blocked
    a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R9: nothing delivered that was never accepted
    a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight != 0);

    // R7: never more tiles in flight than pipeline stages
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 4'(STAGES));

    // R1: empty pipeline shows no result
    a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        inflight == 0 |-> !out_valid && in_ready);

endmodule

bind stencil_tile stencil_tile_chk #(.VW(stencil_pkg::PTS * DW), .STAGES(3)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_vals  (out_vals)
);

// File: tb/tb_stencil_tile.sv
`timescale 1ns/1ps
module tb_stencil_tile;

    localparam int DW = 16;
    localparam int NT = 21;
    localparam int NP = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [NT*DW-1:0]  in_taps = '0;
    logic [DW-1:0]     coef_i = '0, coef_j = '0, coef_c = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [NP*DW-1:0]  out_vals;

    int checks = 0;
    int fails  = 0;
    int waits  = 0;
    bit bp_on  = 0;
    bit done   = 0;
    string cur_req = "R2";
    logic [NP*DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    stencil_tile dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_taps(in_taps), .coef_i(coef_i), .coef_j(coef_j), .coef_c(coef_c),
        .out_valid(out_valid), .out_ready(out_ready), .out_vals(out_vals)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference arithmetic from R2..R6
    function automatic longint clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint rprod(input longint a, input longint b);
        return clamp16((a * b + 128) >>> 8);
    endfunction

    function automatic int tix(input int x, input int y);
        if (y < 0) return x;
        if (y > 2) return 18 + x;
        return 3 + 5 * y + x + 1;
    endfunction

    function automatic longint smp(input logic [NT*DW-1:0] t, input int k);
        return longint'($signed(t[k*DW +: DW]));
    endfunction

    function automatic logic [NP*DW-1:0] ref_tile(input logic [NT*DW-1:0] t,
            input logic [DW-1:0] ci, input logic [DW-1:0] cj, input logic [DW-1:0] cc);
        logic [NP*DW-1:0] r;
        longint a, b, c;
        a = longint'($signed(ci));
        b = longint'($signed(cj));
        c = longint'($signed(cc));
        for (int dj = 0; dj < 3; dj++)
            for (int di = 0; di < 3; di++) begin
                longint v;
                v = rprod(a, smp(t, tix(di-1, dj)) + smp(t, tix(di+1, dj)))
                  + rprod(b, smp(t, tix(di, dj-1)) + smp(t, tix(di, dj+1)))
                  + rprod(c, smp(t, tix(di, dj)));
                r[(dj*3+di)*DW +: DW] = DW'(clamp16(v));
            end
        return r;
    endfunction

    // Output-side backpressure generator
    always @(negedge clk)
        out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;

    // Driver: offer one tile, push expected result when it is taken
    task automatic send(input logic [NT*DW-1:0] t, input logic [DW-1:0] ci,
                        input logic [DW-1:0] cj, input logic [DW-1:0] cc);
        @(negedge clk);
        in_valid = 1'b1;
        in_taps  = t;
        coef_i = ci; coef_j = cj; coef_c = cc;
        #1;
        while (!in_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        exp_q.push_back(ref_tile(t, ci, cj, cc));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each delivered tile, and watch stalled outputs (R8)
    logic [NP*DW-1:0] held;
    bit was_stalled = 0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (was_stalled) begin
                check(out_valid && out_vals == held, "R8", longint'(out_vals[63:0]), longint'(held[63:0]));
            end
            if (out_valid && !out_ready) begin
                check(!in_ready, "R8", longint'(in_ready), 0);
                held = out_vals;
                was_stalled = 1;
            end else begin
                was_stalled = 0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", 1, 0);
                end else begin
                    logic [NP*DW-1:0] e;
                    e = exp_q.pop_front();
                    for (int m = 0; m < NP; m++)
                        check(out_vals[m*DW +: DW] == e[m*DW +: DW], cur_req,
                              longint'(out_vals[m*DW +: DW]), longint'(e[m*DW +: DW]));
                end
            end
        end
    end

    function automatic logic [NT*DW-1:0] rnd_tile();
        logic [NT*DW-1:0] t;
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = DW'($urandom);
        return t;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic drain();
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    endtask

    initial begin
        logic [NT*DW-1:0] t;
        // R1: reset state
        repeat (3) @(negedge clk);
        #3;
        check(out_valid == 0, "R1", out_valid, 0);
        check(in_ready == 1, "R1", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk); #3;
        check(out_valid == 0 && in_ready == 1, "R1", {out_valid, in_ready}, 2'b01);

        // R7: latency of a lone tile with a free output
        cur_req = "R7";
        t = rnd_tile();
        send(t, 16'h0100, 16'h0080, 16'hff00);
        idle();            // N1
        #3; check(out_valid == 0, "R7", out_valid, 0);
        @(negedge clk); #3; check(out_valid == 0, "R7", out_valid, 0);
        @(negedge clk); #3; check(out_valid == 1, "R7", out_valid, 1);
        drain();

        // R3/R4: one-hot samples isolate every input position
        cur_req = "R3";
        for (int k = 0; k < NT; k++) begin
            t = '0;
            t[k*DW +: DW] = 16'h0100;
            send(t, 16'h0100, 16'h0200, 16'h0300);
        end
        idle();
        drain();
        cur_req = "R4";
        for (int m = 0; m < NP; m++) begin
            t = '0;
            t[tix(m % 3, m / 3)*DW +: DW] = 16'h0040;
            send(t, 16'h0000, 16'h0000, 16'h0100);
        end
        idle();
        drain();

        // R5: half-LSB products of both signs
        cur_req = "R5";
        t = '0;
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'h0001;
        send(t, 16'h0000, 16'h0000, 16'h0080);
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'hffff;
        send(t, 16'h0000, 16'h0000, 16'h0080);
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'h0003;
        send(t, 16'h0080, 16'h0040, 16'h0180);
        idle();
        drain();

        // R6: clamping of products and of the final sum
        cur_req = "R6";
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'h7fff;
        send(t, 16'h7fff, 16'h7fff, 16'h7fff);
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'h8000;
        send(t, 16'h7fff, 16'h7fff, 16'h7fff);
        send(t, 16'h8000, 16'h8000, 16'h8000);
        for (int k = 0; k < NT; k++) t[k*DW +: DW] = 16'h4000;
        send(t, 16'h0100, 16'h0100, 16'h0100);
        idle();
        drain();

        // R7: back-to-back throughput with a free output
        cur_req = "R7";
        waits = 0;
        for (int n = 0; n < 12; n++) send(rnd_tile(), DW'($urandom), DW'($urandom), DW'($urandom));
        idle();
        check(waits == 0, "R7", waits, 0);
        drain();

        // R2/R8/R9: random tiles under random output backpressure
        cur_req = "R2";
        bp_on = 1;
        for (int n = 0; n < 300; n++) begin
            send(rnd_tile(), DW'($urandom_range(0, 511)), DW'($urandom_range(0, 511)),
                 DW'($urandom));
            if ($urandom_range(0, 3) == 0) idle();
        end
        idle();
        drain();
        bp_on = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule